// File: doc/BRIEF.md
# Idle-Line Multi-Drop Serial Receiver

This block receives asynchronous serial characters on a shared multi-drop line where blocks of characters are separated by idle gaps. A frame is one start bit (0), eight data bits least significant bit first and one stop bit (1). The receiver counts consecutive mark (1) samples once a character's stop bit has been taken. A gap of ten or more bit times marks a block boundary, and the first character completed after that gap is tagged as the block's address character.

With wake-up filtering switched on, the receiver delivers only address characters. Data characters, together with their valid strobe and error status, are withheld. Software reads the address, decides whether the block is meant for this node, and clears the wake-enable input to receive the data that follows. A format-select input picks between the idle-gap scheme and an address-bit scheme. Only the idle-gap scheme is built here, so selecting the other one turns off address tagging and filtering. Bit timing comes from a single baud-tick enable that pulses once per bit at the middle of the bit. The serial input is expected to be synchronous to the clock already.

Top module: `mp_idle_rx`

## Requirements
- R1: A frame is a 0 start bit, eight data bits sent least significant bit first, then a stop bit. A delivered character appears on rxData. rxValid is high for exactly one clock: the clock after the edge that samples the stop bit on a baud tick.
- R2: A 0 on rxLine while the receiver is idle starts a frame on the next clock edge. If rxLine is 1 at the following baud tick (mid start bit), the frame is dropped, no character is produced and the receiver goes back to idle.
- R3: A 0 sampled at the stop position makes the delivered character carry frameErr=1. breakErr=1 is set when, in addition, all eight data bits are 0. A character with a valid stop bit carries frameErr=0 and breakErr=0.
- R4: While idle, each baud tick that samples a 1 advances an idle count. The count starts from zero after each stop bit and after reset, and stops at ten. idleFlag is set on the tick edge that takes the tenth such sample. Gaps of nine or fewer bits never set it.
- R5: idleFlag is cleared on the clock edge at which a start bit is detected.
- R6: With fmtSel=0, the first character completed after idleFlag has been raised carries addrFlag=1. A false start does not cancel this. A character that follows a gap shorter than ten bits carries addrFlag=0.
- R7: With wakeEn=1 and fmtSel=0, only characters with addrFlag=1 are delivered. A data character produces no rxValid and leaves rxData, addrFlag, frameErr and breakErr unchanged.
- R8: With wakeEn=0, every completed character is delivered, whether it is an address or data character and whether or not it has an error.
- R9: With fmtSel=1 (the address-bit format, not built here), every character is delivered whatever wakeEn is, and addrFlag is always 0.
- R10: rxData, addrFlag, frameErr and breakErr keep their values from one delivered character to the next.
- R11: After reset, rxData is 0 and rxValid, addrFlag, idleFlag, frameErr and breakErr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-clock enable at the middle of each bit time |
| rxLine | input | 1 | Serial input, already synchronous, idle high |
| wakeEn | input | 1 | 1 = deliver address characters only |
| fmtSel | input | 1 | 0 = idle-gap format, 1 = address-bit format (no tagging) |
| rxData | output | 8 | Last delivered character |
| rxValid | output | 1 | One-clock strobe for a delivered character |
| addrFlag | output | 1 | Delivered character started a block |
| idleFlag | output | 1 | A gap of ten or more mark bits has been seen |
| frameErr | output | 1 | Delivered character had a 0 stop bit |
| breakErr | output | 1 | Delivered character was all zeros with a 0 stop bit |

## Verification
A character's outputs change on the clock edge that samples its stop bit on a baud tick. The bench keeps a running count of rxValid-high cycles on the rising clock edge, and compares that count before and after each frame, so a missing, duplicated or stretched strobe shows up as the wrong difference. idleFlag is due on the edge of the tenth idle tick. It is read at the falling edge after the last gap bit ends. Its clearing is due one edge after the line falls, and it is read at the falling edge right after that. All stimulus changes and all reads happen on falling edges, half a clock away from the edges where the design samples.

// File: rtl/mp_idle_rx_pkg.sv
package mp_idle_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_e;

  // strobes issued by the bit-timing control to the datapath
  typedef struct packed {
    logic startSeen;   // falling edge accepted while idle
    logic idleSample;  // baud tick taken while idle
    logic shiftBit;    // data bit sample
    logic stopSample;  // stop bit sample, frame complete
  } rxStrobe_t;
endpackage

// File: rtl/mp_idle_rx_ctrl.sv
module mp_idle_rx_ctrl
  import mp_idle_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       rxLine,
  output rxStrobe_t  strobe
);
  localparam int CW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_BITS - 1);

  rxState_e state, stateNext;
  logic [CW-1:0] bitCnt, bitCntNext;

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strobe     = '0;
    case (state)
      ST_IDLE: begin
        strobe.idleSample = baudTick;
        if (!rxLine) begin
          strobe.startSeen = 1'b1;
          stateNext        = ST_START;
        end
      end
      ST_START: begin
        if (baudTick) begin
          bitCntNext = '0;
          stateNext  = rxLine ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (baudTick) begin
          strobe.shiftBit = 1'b1;
          if (bitCnt == LAST_BIT) stateNext = ST_STOP;
          else bitCntNext = bitCnt + 1'b1;
        end
      end
      ST_STOP: begin
        if (baudTick) begin
          strobe.stopSample = 1'b1;
          stateNext         = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end
endmodule

// File: rtl/mp_idle_rx_dp.sv
module mp_idle_rx_dp
  import mp_idle_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 wakeEn,
  input  logic                 fmtSel,
  input  rxStrobe_t            strobe,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 addrFlag,
  output logic                 idleFlag,
  output logic                 frameErr,
  output logic                 breakErr
);
  localparam int NW = $clog2(IDLE_BITS + 1);
  localparam logic [NW-1:0] IDLE_TOP = NW'(IDLE_BITS);

  logic [DATA_BITS-1:0] shiftReg;
  logic [NW-1:0]        idleCnt;
  logic                 blockPending;
  logic                 idleReach;
  logic                 isAddr;
  logic                 deliver;

  assign idleReach = strobe.idleSample && rxLine && !strobe.startSeen
                     && (idleCnt == IDLE_TOP - 1'b1);
  assign isAddr    = blockPending && !fmtSel;
  assign deliver   = strobe.stopSample && (fmtSel || !wakeEn || isAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg     <= '0;
      idleCnt      <= '0;
      idleFlag     <= 1'b0;
      blockPending <= 1'b0;
    end else begin
      if (strobe.shiftBit) shiftReg <= {rxLine, shiftReg[DATA_BITS-1:1]};

      if (strobe.startSeen || (strobe.idleSample && !rxLine)) idleCnt <= '0;
      else if (strobe.idleSample && idleCnt != IDLE_TOP) idleCnt <= idleCnt + 1'b1;

      if (strobe.startSeen) idleFlag <= 1'b0;
      else if (idleReach)   idleFlag <= 1'b1;

      if (idleReach)              blockPending <= 1'b1;
      else if (strobe.stopSample) blockPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      rxValid  <= 1'b0;
      addrFlag <= 1'b0;
      frameErr <= 1'b0;
      breakErr <= 1'b0;
    end else begin
      rxValid <= deliver;
      if (deliver) begin
        rxData   <= shiftReg;
        addrFlag <= isAddr;
        frameErr <= !rxLine;
        breakErr <= !rxLine && (shiftReg == '0);
      end
    end
  end
endmodule

// File: rtl/mp_idle_rx.sv
module mp_idle_rx
  import mp_idle_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxLine,
  input  logic                 wakeEn,
  input  logic                 fmtSel,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 addrFlag,
  output logic                 idleFlag,
  output logic                 frameErr,
  output logic                 breakErr
);
  rxStrobe_t strobe;

  mp_idle_rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine), .strobe(strobe)
  );

  mp_idle_rx_dp #(.DATA_BITS(DATA_BITS), .IDLE_BITS(IDLE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .wakeEn(wakeEn), .fmtSel(fmtSel),
    .strobe(strobe), .rxData(rxData), .rxValid(rxValid), .addrFlag(addrFlag),
    .idleFlag(idleFlag), .frameErr(frameErr), .breakErr(breakErr)
  );
endmodule

// File: rtl/mp_idle_rx_chk.sv
module mp_idle_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 baudTick,
  input logic                 wakeEn,
  input logic                 fmtSel,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxValid,
  input logic                 addrFlag,
  input logic                 idleFlag,
  input logic                 frameErr,
  input logic                 breakErr
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R1
  AST_BREAK_HAS_FE: assert property (@(posedge clk) disable iff (!rstN)
    breakErr |-> (frameErr && rxData == '0)); // R3
  AST_IDLE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> $past(baudTick)); // R4
  AST_WAKE_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(wakeEn) && !$past(fmtSel)) |-> addrFlag); // R7
  AST_FMT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(fmtSel)) |-> !addrFlag); // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> ($stable(rxData) && $stable(addrFlag) && $stable(frameErr))); // R10
endmodule

bind mp_idle_rx mp_idle_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .wakeEn(wakeEn), .fmtSel(fmtSel),
  .rxData(rxData), .rxValid(rxValid), .addrFlag(addrFlag), .idleFlag(idleFlag),
  .frameErr(frameErr), .breakErr(breakErr)
);

// File: tb/mp_idle_rx_tb.sv
module mp_idle_rx_tb;
  localparam int BIT_CLKS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic rxLine = 1'b1;
  logic wakeEn = 1'b0;
  logic fmtSel = 1'b0;
  logic [7:0] rxData;
  logic rxValid, addrFlag, idleFlag, frameErr, breakErr;

  int testsRun = 0;
  int testsFailed = 0;
  int validCnt = 0;
  logic idleAtStart;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rxValid) validCnt <= validCnt + 1;

  mp_idle_rx u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine),
    .wakeEn(wakeEn), .fmtSel(fmtSel), .rxData(rxData), .rxValid(rxValid),
    .addrFlag(addrFlag), .idleFlag(idleFlag), .frameErr(frameErr), .breakErr(breakErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // the bit time is BIT_CLKS clocks; the tick falls in the middle
  task automatic bitRest();
    repeat (2) @(negedge clk);
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
    repeat (BIT_CLKS - 4) @(negedge clk);
  endtask

  task automatic sendBit(input logic v);
    rxLine = v;
    @(negedge clk);
    bitRest();
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopV);
    rxLine = 1'b0;
    @(negedge clk);
    idleAtStart = idleFlag;
    bitRest();
    for (int i = 0; i < 8; i++) sendBit(b[i]);
    sendBit(stopV);
  endtask

  // send one frame and check the rxValid count plus all held outputs
  task automatic frameCheck(input logic [7:0] b, input logic stopV, input bit expDeliver,
                            input logic [7:0] expData, input logic expAddr,
                            input logic expFe, input logic expBe, input string req);
    int v0;
    v0 = validCnt;
    sendFrame(b, stopV);
    check(validCnt - v0 == (expDeliver ? 1 : 0), req, validCnt - v0, expDeliver ? 1 : 0);
    check(rxData == expData, req, rxData, expData);
    check(addrFlag == expAddr, req, addrFlag, expAddr);
    check(frameErr == expFe && breakErr == expBe, req, {frameErr, breakErr}, {expFe, expBe});
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check({rxData, rxValid, addrFlag, idleFlag, frameErr, breakErr} == '0, "R11",
          {rxData, rxValid, addrFlag, idleFlag, frameErr, breakErr}, 0);

    // R4 R6 R8: sweep of the idle gap length around the threshold
    gap(12);
    for (int n = 0; n <= 12; n++) begin
      logic [7:0] b;
      b = 8'(n * 19 + 3);
      sendFrame(8'hA5, 1'b1);
      gap(n);
      check(idleFlag == (n >= 10), "R4", idleFlag, n >= 10);
      frameCheck(b, 1'b1, 1'b1, b, n >= 10, 1'b0, 1'b0, "R6 R8");
      if (n >= 10) check(idleAtStart == 1'b0, "R5", idleAtStart, 0);
    end

    // R1: every byte value, LSB first
    for (int b = 0; b < 256; b++) begin
      int v0;
      v0 = validCnt;
      gap(1);
      sendFrame(8'(b), 1'b1);
      check(rxData == 8'(b) && validCnt - v0 == 1, "R1", rxData, b);
    end

    // R7 R10: wake filter passes addresses only
    wakeEn = 1'b1;
    gap(12);
    frameCheck(8'hC3, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, "R7");
    gap(3);
    frameCheck(8'h3C, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b0, 1'b0, "R7 R10");
    gap(2);
    frameCheck(8'h00, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b0, 1'b0, "R7 R10");
    wakeEn = 1'b0;
    gap(2);
    frameCheck(8'h99, 1'b1, 1'b1, 8'h99, 1'b0, 1'b0, 1'b0, "R8");

    // R2: false start leaves no character and keeps the pending block start
    gap(12);
    begin
      int v0;
      v0 = validCnt;
      rxLine = 1'b0;
      repeat (2) @(negedge clk);
      rxLine = 1'b1;
      bitRest();
      gap(2);
      check(validCnt == v0, "R2", validCnt - v0, 0);
    end
    frameCheck(8'h6D, 1'b1, 1'b1, 8'h6D, 1'b1, 1'b0, 1'b0, "R2 R6");

    // R3: framing and break errors
    gap(12);
    frameCheck(8'h5A, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, "R3");
    gap(12);
    frameCheck(8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, "R3");
    gap(12);
    frameCheck(8'h7E, 1'b1, 1'b1, 8'h7E, 1'b1, 1'b0, 1'b0, "R3");

    // R9: address-bit format selected, no tagging and no filtering
    fmtSel = 1'b1;
    wakeEn = 1'b1;
    gap(12);
    frameCheck(8'h81, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0, "R9");
    gap(1);
    frameCheck(8'h18, 1'b1, 1'b1, 8'h18, 1'b0, 1'b0, 1'b0, "R9");
    fmtSel = 1'b0;
    wakeEn = 1'b0;
    gap(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule